// File: doc/BRIEF.md
# Area Chip-Select Generator

This block turns the external address bus of a processor into eight active-low chip-select lines. The 16 MB address space is split into eight equal 2 MB areas, and the area number comes from the top three address bits. A select line goes low only while the bus strobe is active, the address lies in that area, and the access is not aimed at on-chip ROM, RAM or the register window. On-chip accesses keep every line high, so external SRAM and other devices can use the selects directly.

Each select line has its own output enable, and a disabled line is left undriven, so the pad is high-impedance. Enables for lines 0 to 3 come from the low four bits of a port direction register. Enables for lines 4 to 7 come from the high four bits of a separate select control register. Both registers share one byte-wide write port and can be read back. The ROM-enable mode strap is captured only while reset is asserted. With ROM off, line 0 is driven from reset, so the boot device is reachable. With ROM on, the on-chip ROM window is treated as internal and all enables start off.

Top module: `area_cs_gen`

## Requirements
- R1: While bus_stb_i is 1 and the access is external, cs_n_o[k] is 0 exactly when addr_i[23:21] equals k. All other bits are 1, so at most one bit of cs_n_o is 0.
- R2: While bus_stb_i is 0, cs_n_o is 8'hFF whatever the address.
- R3: If the captured mode is ROM enabled, addresses 24'h000000 to 24'h01FFFF are internal and cs_n_o is 8'hFF. If the captured mode is ROM disabled, the same addresses select area 0.
- R4: Addresses 24'hFFE000 to 24'hFFEFFF (RAM) and 24'hFFFF00 to 24'hFFFFFF (registers) are internal in both modes, and cs_n_o stays 8'hFF for them.
- R5: cs_oe_o[3:0] equals bits 3:0 of the port direction register. A 1 means the pin is driven.
- R6: cs_oe_o[7:4] equals bits 7:4 of the select control register. A 1 means the pin is driven.
- R7: During and after reset, the select control register is 8'h00. The port direction register is 8'h01 when rom_en_i is 0 at reset and 8'h00 when rom_en_i is 1 at reset.
- R8: When reg_we_i is 1 at a rising clock edge, reg_wdata_i is written to the register chosen by reg_sel_i (0 = port direction, 1 = select control). reg_rdata_o shows the chosen register without delay. Bits 3:0 of the select control register always read 0 and ignore writes. With reg_we_i at 0, neither register changes.
- R9: rom_en_i is only used while rst_ni is 0. Changing it after reset alters neither the internal ROM window nor the enables.
- R10: cs_n_o carries the decoded value even when the matching cs_oe_o bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rom_en_i | input | 1 | Mode strap, 1 = on-chip ROM enabled, captured during reset |
| bus_stb_i | input | 1 | External bus strobe, 1 while an access is in progress |
| addr_i | input | 24 | Address bus |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 port direction, 1 select control |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read-back of the selected register |
| cs_n_o | output | 8 | Active-low chip-select values |
| cs_oe_o | output | 8 | Per-pin output enable, 1 drives the pin |

## Verification
The checker watches the following on every cycle:
- No more than one select is low, and a low select matches the area bits of the address.
- An idle strobe and an access to the RAM window both give all-high outputs.
- The low enables follow the port direction read-back.
- A write reaches the enables one cycle later, and the enables stay put when no write happens.

The behaviours that depend on the mode only show up in the bench's scenarios: the reset defaults in each mode, ROM-window suppression, the strap being ignored after reset, and decoding while the pin is undriven. The bench covers these by resetting in both modes and comparing against its own model on every cycle.

// File: rtl/area_cs_pkg.sv
package area_cs_pkg;
  localparam int unsigned ADDR_W  = 24;
  localparam int unsigned N_AREA  = 8;
  localparam int unsigned N_LOW   = 4;
  localparam int unsigned DATA_W  = 8;

  typedef enum logic {
    SEL_PORT_DIR = 1'b0,
    SEL_CS_CTRL  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/area_cs_decode.sv
module area_cs_decode #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned N_AREA = 8,
  parameter logic [ADDR_W-1:0] ROM_BASE = 24'h000000,
  parameter logic [ADDR_W-1:0] ROM_SIZE = 24'h020000,
  parameter logic [ADDR_W-1:0] RAM_BASE = 24'hFFE000,
  parameter logic [ADDR_W-1:0] RAM_SIZE = 24'h001000,
  parameter logic [ADDR_W-1:0] REG_BASE = 24'hFFFF00,
  parameter logic [ADDR_W-1:0] REG_SIZE = 24'h000100
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rom_on_i,
  input  logic              bus_stb_i,
  output logic [N_AREA-1:0] sel_o,
  output logic              int_hit_o
);
  localparam int unsigned AREA_W = $clog2(N_AREA);
  localparam logic [ADDR_W-1:0] ROM_MASK = ~(ROM_SIZE - 1'b1);
  localparam logic [ADDR_W-1:0] RAM_MASK = ~(RAM_SIZE - 1'b1);
  localparam logic [ADDR_W-1:0] REG_MASK = ~(REG_SIZE - 1'b1);

  logic [AREA_W-1:0] area;
  logic rom_hit, ram_hit, reg_hit, ext_acc;

  assign area    = addr_i[ADDR_W-1 -: AREA_W];
  assign rom_hit = rom_on_i && ((addr_i & ROM_MASK) == ROM_BASE);
  assign ram_hit = (addr_i & RAM_MASK) == RAM_BASE;
  assign reg_hit = (addr_i & REG_MASK) == REG_BASE;
  assign int_hit_o = rom_hit | ram_hit | reg_hit;
  assign ext_acc = bus_stb_i & ~int_hit_o;

  for (genvar k = 0; k < N_AREA; k++) begin : g_area
    assign sel_o[k] = ext_acc && (area == AREA_W'(k));
  end
endmodule

// File: rtl/area_cs_en_regs.sv
module area_cs_en_regs #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_AREA = 8,
  parameter int unsigned N_LOW  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rom_strap_i,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] port_dir_o,
  output logic [DATA_W-1:0] cs_ctrl_o,
  output logic              rom_on_o
);
  import area_cs_pkg::*;

  localparam logic [DATA_W-1:0] HI_MASK  = DATA_W'((1 << N_AREA) - 1);
  localparam logic [DATA_W-1:0] LO_MASK  = DATA_W'((1 << N_LOW) - 1);
  localparam logic [DATA_W-1:0] CTL_MASK = HI_MASK & ~LO_MASK;

  logic [DATA_W-1:0] port_dir_q, cs_ctrl_q;
  logic              rom_on_q;

  // strap is a reset value: held only while rst_ni is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_on_q   <= rom_strap_i;
      port_dir_q <= {{(DATA_W-1){1'b0}}, ~rom_strap_i};
      cs_ctrl_q  <= '0;
    end else if (we_i) begin
      if (reg_sel_e'(sel_i) == SEL_PORT_DIR) port_dir_q <= wdata_i;
      else                                   cs_ctrl_q  <= wdata_i & CTL_MASK;
    end
  end

  assign rdata_o    = (reg_sel_e'(sel_i) == SEL_PORT_DIR) ? port_dir_q : cs_ctrl_q;
  assign port_dir_o = port_dir_q;
  assign cs_ctrl_o  = cs_ctrl_q;
  assign rom_on_o   = rom_on_q;
endmodule

// File: rtl/area_cs_pad.sv
module area_cs_pad #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_AREA = 8,
  parameter int unsigned N_LOW  = 4
) (
  input  logic [N_AREA-1:0] sel_i,
  input  logic [DATA_W-1:0] port_dir_i,
  input  logic [DATA_W-1:0] cs_ctrl_i,
  output logic [N_AREA-1:0] cs_n_o,
  output logic [N_AREA-1:0] cs_oe_o
);
  for (genvar k = 0; k < N_AREA; k++) begin : g_pin
    assign cs_n_o[k] = ~sel_i[k];
    if (k < N_LOW) begin : g_low
      assign cs_oe_o[k] = port_dir_i[k];
    end else begin : g_high
      assign cs_oe_o[k] = cs_ctrl_i[k];
    end
  end
endmodule

// File: rtl/area_cs_gen.sv
module area_cs_gen #(
  parameter int unsigned ADDR_W = area_cs_pkg::ADDR_W,
  parameter int unsigned N_AREA = area_cs_pkg::N_AREA,
  parameter int unsigned N_LOW  = area_cs_pkg::N_LOW,
  parameter int unsigned DATA_W = area_cs_pkg::DATA_W,
  parameter logic [ADDR_W-1:0] ROM_BASE = 24'h000000,
  parameter logic [ADDR_W-1:0] ROM_SIZE = 24'h020000,
  parameter logic [ADDR_W-1:0] RAM_BASE = 24'hFFE000,
  parameter logic [ADDR_W-1:0] RAM_SIZE = 24'h001000,
  parameter logic [ADDR_W-1:0] REG_BASE = 24'hFFFF00,
  parameter logic [ADDR_W-1:0] REG_SIZE = 24'h000100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rom_en_i,
  input  logic              bus_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N_AREA-1:0] cs_n_o,
  output logic [N_AREA-1:0] cs_oe_o
);
  logic [N_AREA-1:0] sel;
  logic              int_hit;
  logic              rom_on;
  logic [DATA_W-1:0] port_dir, cs_ctrl;

  area_cs_en_regs #(.DATA_W(DATA_W), .N_AREA(N_AREA), .N_LOW(N_LOW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rom_strap_i(rom_en_i),
    .we_i       (reg_we_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .port_dir_o (port_dir),
    .cs_ctrl_o  (cs_ctrl),
    .rom_on_o   (rom_on)
  );

  area_cs_decode #(
    .ADDR_W(ADDR_W), .N_AREA(N_AREA),
    .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE),
    .RAM_BASE(RAM_BASE), .RAM_SIZE(RAM_SIZE),
    .REG_BASE(REG_BASE), .REG_SIZE(REG_SIZE)
  ) u_dec (
    .addr_i   (addr_i),
    .rom_on_i (rom_on),
    .bus_stb_i(bus_stb_i),
    .sel_o    (sel),
    .int_hit_o(int_hit)
  );

  area_cs_pad #(.DATA_W(DATA_W), .N_AREA(N_AREA), .N_LOW(N_LOW)) u_pad (
    .sel_i     (sel),
    .port_dir_i(port_dir),
    .cs_ctrl_i (cs_ctrl),
    .cs_n_o    (cs_n_o),
    .cs_oe_o   (cs_oe_o)
  );

  logic unused_int_hit;
  assign unused_int_hit = int_hit;
endmodule

// File: rtl/area_cs_chk.sv
module area_cs_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned N_AREA = 8,
  parameter int unsigned N_LOW  = 4,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] RAM_BASE = 24'hFFE000,
  parameter logic [ADDR_W-1:0] RAM_SIZE = 24'h001000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_stb_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              reg_we_i,
  input logic              reg_sel_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [N_AREA-1:0] cs_n_o,
  input logic [N_AREA-1:0] cs_oe_o
);
  localparam int unsigned AREA_W = $clog2(N_AREA);
  logic in_ram;
  assign in_ram = (addr_i >= RAM_BASE) && (addr_i <= RAM_BASE + (RAM_SIZE - 1'b1));

  a_r1_one_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_n_o) <= 1);

  for (genvar k = 0; k < N_AREA; k++) begin : g_area_chk
    a_r1_area_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cs_n_o[k] |-> (addr_i[ADDR_W-1 -: AREA_W] == AREA_W'(k)));
  end

  a_r2_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_stb_i |-> (&cs_n_o));

  a_r4_ram_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ram |-> (&cs_n_o));

  a_r5_low_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> (cs_oe_o[N_LOW-1:0] == reg_rdata_o[N_LOW-1:0]));

  a_r8_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i) |=> (cs_oe_o[N_AREA-1:N_LOW] == $past(reg_wdata_i[N_AREA-1:N_LOW])));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> $stable(cs_oe_o));
endmodule

bind area_cs_gen area_cs_chk #(
  .ADDR_W(ADDR_W), .N_AREA(N_AREA), .N_LOW(N_LOW), .DATA_W(DATA_W),
  .RAM_BASE(RAM_BASE), .RAM_SIZE(RAM_SIZE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_stb_i  (bus_stb_i),
  .addr_i     (addr_i),
  .reg_we_i   (reg_we_i),
  .reg_sel_i  (reg_sel_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .cs_n_o     (cs_n_o),
  .cs_oe_o    (cs_oe_o)
);

// File: tb/area_cs_gen_tb_top.sv
module area_cs_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        rom_en_i = 0;
  logic        bus_stb_i = 0;
  logic [23:0] addr_i = '0;
  logic        reg_we_i = 0;
  logic        reg_sel_i = 0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic [7:0]  cs_n_o;
  logic [7:0]  cs_oe_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R7";

  // reference state
  logic [7:0] ddr_m, ctl_m;
  bit         mode_m;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  area_cs_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rom_en_i(rom_en_i), .bus_stb_i(bus_stb_i),
    .addr_i(addr_i), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .cs_n_o(cs_n_o), .cs_oe_o(cs_oe_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_m <= rom_en_i;
      ddr_m  <= rom_en_i ? 8'h00 : 8'h01;
      ctl_m  <= 8'h00;
    end else if (reg_we_i) begin
      if (reg_sel_i) ctl_m <= {reg_wdata_i[7:4], 4'h0};
      else           ddr_m <= reg_wdata_i;
    end
  end

  function automatic logic [7:0] exp_cs(input int unsigned a, input bit stb, input bit m);
    bit internal;
    internal = (m && a < 32'h020000) ||
               (a >= 32'hFFE000 && a < 32'hFFF000) ||
               (a >= 32'hFFFF00 && a <= 32'hFFFFFF);
    if (!stb || internal) return 8'hFF;
    return ~(8'h01 << (a / 32'h200000));
  endfunction

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, expv, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(cur_req, "cs_n_o", cs_n_o, exp_cs(addr_i, bus_stb_i, mode_m));
      chk(cur_req, "cs_oe_o", cs_oe_o, {ctl_m[7:4], ddr_m[3:0]});
      chk(cur_req, "reg_rdata_o", reg_rdata_o, reg_sel_i ? ctl_m : ddr_m);
    end
  end

  task automatic drive(input logic [23:0] a, input bit stb, input string req);
    @(posedge clk_i); #1;
    addr_i = a; bus_stb_i = stb; cur_req = req;
  endtask

  task automatic wr(input bit sel, input logic [7:0] d, input string req);
    @(posedge clk_i); #1;
    reg_we_i = 1; reg_sel_i = sel; reg_wdata_i = d; cur_req = req;
    @(posedge clk_i); #1;
    reg_we_i = 0;
  endtask

  task automatic do_reset(input bit mode);
    @(posedge clk_i); #1;
    rom_en_i = mode; bus_stb_i = 0; reg_we_i = 0; rst_ni = 0;
    #(CLK_PERIOD*2);
    reg_sel_i = 0; #1;
    chk("R7", "port dir at reset", reg_rdata_o, mode ? 8'h00 : 8'h01);
    reg_sel_i = 1; #1;
    chk("R7", "cs ctrl at reset", reg_rdata_o, 8'h00);
    chk("R7", "oe at reset", cs_oe_o, mode ? 8'h00 : 8'h01);
    @(posedge clk_i); #1;
    rst_ni = 1;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset(0);
    // sweep areas, ROM disabled: low ROM window is external area 0
    for (int k = 0; k < 8; k++) drive(24'(k) << 21 | 24'h001234, 1, "R1");
    drive(24'h001000, 1, "R3");
    drive(24'h01FFFF, 1, "R3");
    for (int k = 0; k < 8; k++) drive(24'(k) << 21, 0, "R2");
    drive(24'hFFE000, 1, "R4");
    drive(24'hFFEFFF, 1, "R4");
    drive(24'hFFFF80, 1, "R4");
    drive(24'hFFDFFF, 1, "R4");
    drive(24'hFFF000, 1, "R4");
    // enables
    wr(0, 8'h0A, "R5");
    drive(24'h400000, 1, "R5");
    wr(1, 8'hFF, "R6");
    drive(24'hA00000, 1, "R6");
    wr(1, 8'h5A, "R8");
    drive(24'h000000, 0, "R8");
    @(posedge clk_i); #1; reg_sel_i = 1; reg_wdata_i = 8'hFF; cur_req = "R8";
    @(posedge clk_i); #1; reg_sel_i = 0; reg_wdata_i = 8'h00;
    @(posedge clk_i); #1;
    // strap change after reset ignored
    rom_en_i = 1;
    drive(24'h000100, 1, "R9");
    drive(24'h010000, 1, "R9");
    // ROM enabled mode
    do_reset(1);
    drive(24'h000100, 1, "R3");
    drive(24'h01FFFF, 1, "R3");
    drive(24'h020000, 1, "R3");
    drive(24'h4C0000, 1, "R10");
    drive(24'hE00010, 1, "R10");
    rom_en_i = 0;
    drive(24'h000040, 1, "R9");
    wr(0, 8'hF1, "R5");
    drive(24'h200000, 1, "R1");
    drive(24'hFFEFFF, 1, "R4");
    @(posedge clk_i); #1;
    @(negedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule